// File: doc/BRIEF.md
# Two-Key Register Write Lock

This block guards a bank of peripheral registers against stray writes. It sits on the write path of a simple register bus, between the bus and the guarded bank, and decides for each bus write whether it reaches the bank. Writes into the guarded address window are passed on only while two separate 32-bit key registers both hold their own fixed magic value. Writes outside the window and away from the keys always pass.

To open the bank, software writes the first magic value to the first key address and the second magic value to the second key address, in either order. Writing zero, or any other wrong value, to either key closes the bank again from the next write on. The block keeps only one armed flag per key, so a key read on the bus returns zero and the key values cannot be recovered. All outputs are registered, so each accepted write appears on the bank side one clock after it was seen on the bus.

Top module: `regwl_gate`

## Requirements
- R1: After reset both keys are disarmed, and a write into the guarded window (byte addresses 0x00 to 0x5F) in the first cycle after reset does not reach the bank.
- R2: A write of 0x83E70B13 to address 0x6C arms the first key and a write of 0x95A4F1E0 to address 0x70 arms the second; with both armed, a guarded write reaches the bank with its address and data unchanged.
- R3: With only one key armed, writes into the guarded window are still dropped.
- R4: A write of any value other than its magic value, zero included, disarms that key at once, so the next guarded write is dropped.
- R5: While the bank is locked, a guarded write is dropped silently: bank_we stays low for it.
- R6: A write to an address outside the guarded window that is not a key address reaches the bank whether the bank is locked or not.
- R7: A write to either key address is never forwarded to the bank.
- R8: A read of either key address raises key_rd_hit one cycle later with key_rd_data equal to zero; reads of other addresses leave key_rd_hit low.
- R9: Each forwarded write shows on bank_we for exactly one cycle, one clock after the bus write, and bank_we is low in cycles that follow no forwarded write.
- R10: The two keys may be armed in either order with the same result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_wr | input | 1 | Bus write strobe, one cycle per write |
| bus_waddr | input | ADDR_W | Byte address of the bus write |
| bus_wdata | input | DATA_W | Data of the bus write |
| bus_rd | input | 1 | Bus read strobe |
| bus_raddr | input | ADDR_W | Byte address of the bus read |
| bank_we | output | 1 | Write enable toward the guarded bank |
| bank_addr | output | ADDR_W | Address of the forwarded write |
| bank_wdata | output | DATA_W | Data of the forwarded write |
| key_rd_hit | output | 1 | The previous read addressed a key register |
| key_rd_data | output | DATA_W | Read data for a key read, always zero |

## Verification
A wrong key flag shows at the ports on the very next guarded write: a flag stuck armed lets a write through that should be dropped, and a flag stuck clear drops a write that should pass, each visible on bank_we one clock after the bus write. A wrong window or key decode shows the same way, as a write forwarded to or withheld from the bank in that one cycle. The bench therefore follows every bus write with a check in the next cycle, under both directed sequences (partial unlock, reversed order, relock by zero and by a wrong value) and a long random mix.

// File: rtl/regwl_pkg.sv
package regwl_pkg;
  typedef enum logic [1:0] {
    CLS_OPEN = 2'd0,
    CLS_PROT = 2'd1,
    CLS_KEY0 = 2'd2,
    CLS_KEY1 = 2'd3
  } addr_cls_e;

  localparam int unsigned NKEYS = 2;
endpackage

// File: rtl/regwl_decode.sv
module regwl_decode
  import regwl_pkg::*;
#(
  parameter int unsigned ADDR_W    = 8,
  parameter int unsigned PROT_BASE = 'h00,
  parameter int unsigned PROT_SIZE = 'h60,
  parameter int unsigned KEY0_ADDR = 'h6C,
  parameter int unsigned KEY1_ADDR = 'h70
) (
  input  logic [ADDR_W-1:0] addr,
  output addr_cls_e         cls
);
  logic [ADDR_W-1:0] offset;

  always_comb begin
    offset = addr - ADDR_W'(PROT_BASE);
    if (addr == ADDR_W'(KEY0_ADDR))
      cls = CLS_KEY0;
    else if (addr == ADDR_W'(KEY1_ADDR))
      cls = CLS_KEY1;
    else if (offset < ADDR_W'(PROT_SIZE))
      cls = CLS_PROT;
    else
      cls = CLS_OPEN;
  end
endmodule

// File: rtl/regwl_key_slot.sv
module regwl_key_slot #(
  parameter int unsigned DATA_W = 32,
  parameter logic [DATA_W-1:0] MAGIC = '0
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr,
  input  logic [DATA_W-1:0] wdata,
  output logic              armed
);
  always_ff @(posedge clk) begin
    if (rst)
      armed <= 1'b0;
    else if (wr)
      armed <= (wdata == MAGIC);
  end

  assert_magic_arms_R2: assert property (@(posedge clk) disable iff (rst)
    (wr && wdata == MAGIC) |=> armed);

  assert_wrong_value_disarms_R4: assert property (@(posedge clk) disable iff (rst)
    (wr && wdata != MAGIC) |=> !armed);

  assert_idle_holds_R4: assert property (@(posedge clk) disable iff (rst)
    !wr |=> $stable(armed));
endmodule

// File: rtl/regwl_gate.sv
module regwl_gate
  import regwl_pkg::*;
#(
  parameter int unsigned ADDR_W     = 8,
  parameter int unsigned DATA_W     = 32,
  parameter int unsigned PROT_BASE  = 'h00,
  parameter int unsigned PROT_SIZE  = 'h60,
  parameter int unsigned KEY0_ADDR  = 'h6C,
  parameter int unsigned KEY1_ADDR  = 'h70,
  parameter logic [DATA_W-1:0] KEY0_MAGIC = 32'h83E70B13,
  parameter logic [DATA_W-1:0] KEY1_MAGIC = 32'h95A4F1E0
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              bus_wr,
  input  logic [ADDR_W-1:0] bus_waddr,
  input  logic [DATA_W-1:0] bus_wdata,
  input  logic              bus_rd,
  input  logic [ADDR_W-1:0] bus_raddr,
  output logic              bank_we,
  output logic [ADDR_W-1:0] bank_addr,
  output logic [DATA_W-1:0] bank_wdata,
  output logic              key_rd_hit,
  output logic [DATA_W-1:0] key_rd_data
);
  addr_cls_e        wcls, rcls, bcls;
  logic [NKEYS-1:0] key_armed;
  logic             unlocked;
  logic             pass;

  regwl_decode #(
    .ADDR_W(ADDR_W), .PROT_BASE(PROT_BASE), .PROT_SIZE(PROT_SIZE),
    .KEY0_ADDR(KEY0_ADDR), .KEY1_ADDR(KEY1_ADDR)
  ) u_wdec (.addr(bus_waddr), .cls(wcls));

  regwl_decode #(
    .ADDR_W(ADDR_W), .PROT_BASE(PROT_BASE), .PROT_SIZE(PROT_SIZE),
    .KEY0_ADDR(KEY0_ADDR), .KEY1_ADDR(KEY1_ADDR)
  ) u_rdec (.addr(bus_raddr), .cls(rcls));

  // decode of the outgoing address, used only by the checks below
  regwl_decode #(
    .ADDR_W(ADDR_W), .PROT_BASE(PROT_BASE), .PROT_SIZE(PROT_SIZE),
    .KEY0_ADDR(KEY0_ADDR), .KEY1_ADDR(KEY1_ADDR)
  ) u_bdec (.addr(bank_addr), .cls(bcls));

  for (genvar gi = 0; gi < NKEYS; gi++) begin : g_key
    localparam logic [DATA_W-1:0] SLOT_MAGIC = (gi == 0) ? KEY0_MAGIC : KEY1_MAGIC;
    localparam addr_cls_e SLOT_CLS = (gi == 0) ? CLS_KEY0 : CLS_KEY1;
    regwl_key_slot #(.DATA_W(DATA_W), .MAGIC(SLOT_MAGIC)) u_slot (
      .clk   (clk),
      .rst   (rst),
      .wr    (bus_wr && wcls == SLOT_CLS),
      .wdata (bus_wdata),
      .armed (key_armed[gi])
    );
  end

  assign unlocked = &key_armed;
  assign pass = bus_wr && ((wcls == CLS_OPEN) || (wcls == CLS_PROT && unlocked));

  always_ff @(posedge clk) begin
    if (rst) begin
      bank_we    <= 1'b0;
      bank_addr  <= '0;
      bank_wdata <= '0;
      key_rd_hit <= 1'b0;
    end else begin
      bank_we    <= pass;
      key_rd_hit <= bus_rd && (rcls == CLS_KEY0 || rcls == CLS_KEY1);
      if (pass) begin
        bank_addr  <= bus_waddr;
        bank_wdata <= bus_wdata;
      end
    end
  end

  // keys never read back: the stored state is a flag, not the value
  assign key_rd_data = '0;

  assert_locked_after_reset_R1: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> !unlocked);

  assert_guarded_needs_keys_R3: assert property (@(posedge clk) disable iff (rst)
    (bank_we && bcls == CLS_PROT) |-> $past(unlocked));

  assert_key_not_forwarded_R7: assert property (@(posedge clk) disable iff (rst)
    bank_we |-> (bcls == CLS_OPEN || bcls == CLS_PROT));

  assert_open_passes_R6: assert property (@(posedge clk) disable iff (rst)
    (bus_wr && wcls == CLS_OPEN) |=> (bank_we && bank_addr == $past(bus_waddr)));

  assert_locked_drop_R5: assert property (@(posedge clk) disable iff (rst)
    (bus_wr && wcls == CLS_PROT && !unlocked) |=> !bank_we);
endmodule

// File: tb/regwl_gate_tb.sv
`timescale 1ns/1ps
module regwl_gate_tb;
  localparam logic [7:0]  K0A = 8'h6C;
  localparam logic [7:0]  K1A = 8'h70;
  localparam logic [31:0] M0  = 32'h83E70B13;
  localparam logic [31:0] M1  = 32'h95A4F1E0;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        bus_wr = 1'b0;
  logic [7:0]  bus_waddr = '0;
  logic [31:0] bus_wdata = '0;
  logic        bus_rd = 1'b0;
  logic [7:0]  bus_raddr = '0;
  logic        bank_we;
  logic [7:0]  bank_addr;
  logic [31:0] bank_wdata;
  logic        key_rd_hit;
  logic [31:0] key_rd_data;

  int n_run = 0;
  int n_fail = 0;
  bit k0 = 1'b0;
  bit k1 = 1'b0;

  always #2.5 clk = ~clk;

  regwl_gate u_dut (
    .clk(clk), .rst(rst),
    .bus_wr(bus_wr), .bus_waddr(bus_waddr), .bus_wdata(bus_wdata),
    .bus_rd(bus_rd), .bus_raddr(bus_raddr),
    .bank_we(bank_we), .bank_addr(bank_addr), .bank_wdata(bank_wdata),
    .key_rd_hit(key_rd_hit), .key_rd_data(key_rd_data)
  );

  function automatic bit is_key(logic [7:0] a);
    return (a == K0A) || (a == K1A);
  endfunction

  function automatic bit exp_pass(bit w, logic [7:0] a, bit o0, bit o1);
    if (!w || is_key(a)) return 1'b0;
    if (a < 8'h60) return o0 && o1;
    return 1'b1;
  endfunction

  task automatic chk(string tag, logic [63:0] act, logic [63:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // called at a falling edge; checks the registered result one clock later
  task automatic step(string tag, bit w, logic [7:0] a, logic [31:0] d,
                      bit r, logic [7:0] ra);
    bit ew, eh;
    bus_wr = w; bus_waddr = a; bus_wdata = d;
    bus_rd = r; bus_raddr = ra;
    ew = exp_pass(w, a, k0, k1);
    eh = r && is_key(ra);
    if (w && a == K0A) k0 = (d == M0);
    if (w && a == K1A) k1 = (d == M1);
    @(negedge clk);
    chk({tag, " we"}, 64'(bank_we), 64'(ew));
    if (ew) begin
      chk({tag, " addr"}, 64'(bank_addr), 64'(a));
      chk({tag, " data"}, 64'(bank_wdata), 64'(d));
    end
    chk({tag, " rdhit"}, 64'(key_rd_hit), 64'(eh));
    if (eh) chk({tag, " rddata"}, 64'(key_rd_data), 64'd0);
  endtask

  task automatic finish_run();
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  endtask

  initial begin
    #200000;
    n_fail++;
    $display("FAIL watchdog actual=timeout expected=done");
    finish_run();
  end

  initial begin
    void'($urandom(32'd4242));
    repeat (3) @(negedge clk);
    chk("R1 reset we", 64'(bank_we), 64'd0);
    chk("R1 reset rdhit", 64'(key_rd_hit), 64'd0);
    rst = 1'b0;

    step("R1 guarded after reset", 1, 8'h04, 32'h11, 0, 0);
    step("R5 locked guarded", 1, 8'h40, 32'h22, 0, 0);
    step("R9 idle", 0, 8'h00, 32'h0, 0, 0);
    step("R6 open while locked", 1, 8'h80, 32'hA5A5, 0, 0);
    step("R7 key0 write", 1, K0A, M0, 0, 0);
    step("R3 only key0", 1, 8'h08, 32'h33, 0, 0);
    step("R4 relock key0 by zero", 1, K0A, 32'h0, 0, 0);
    step("R7 key1 write", 1, K1A, M1, 0, 0);
    step("R3 only key1", 1, 8'h0C, 32'h44, 0, 0);
    step("R10 key0 second", 1, K0A, M0, 0, 0);
    step("R10 guarded after reverse", 1, 8'h10, 32'h55, 0, 0);
    step("R2 guarded unlocked", 1, 8'h5C, 32'hDEADBEEF, 0, 0);
    step("R9 drop after write", 0, 8'h00, 32'h0, 0, 0);
    step("R8 read key0", 0, 8'h00, 32'h0, 1, K0A);
    step("R8 read key1", 0, 8'h00, 32'h0, 1, K1A);
    step("R8 read other", 0, 8'h00, 32'h0, 1, 8'h10);
    step("R4 wrong key1", 1, K1A, M1 ^ 32'h1, 0, 0);
    step("R4 blocked after wrong", 1, 8'h14, 32'h66, 0, 0);
    step("R2 rearm key1", 1, K1A, M1, 0, 0);
    step("R2 guarded again", 1, 8'h00, 32'h77, 0, 0);
    step("R4 zero key0", 1, K0A, 32'h0, 0, 0);
    step("R4 zero key1", 1, K1A, 32'h0, 0, 0);
    step("R4 blocked after zero", 1, 8'h18, 32'h88, 0, 0);
    step("R6 open edge 0x60", 1, 8'h60, 32'h99, 0, 0);

    for (int i = 0; i < 4000; i++) begin
      int sel;
      logic [7:0] a;
      logic [31:0] d;
      sel = int'($urandom % 8);
      d = $urandom;
      case (sel)
        0: begin a = K0A; if ($urandom % 2 == 0) d = M0; end
        1: begin a = K1A; if ($urandom % 2 == 0) d = M1; end
        2, 3, 4: a = 8'(($urandom % 24) * 4);
        5: a = 8'h60 + 8'(($urandom % 3) * 4);
        default: a = 8'h74 + 8'(($urandom % 35) * 4);
      endcase
      step("R2 R3 R4 R6 random", ($urandom % 4) != 0, a, d,
           ($urandom % 3) == 0, (($urandom % 2) == 0) ? K1A : 8'($urandom));
    end
    finish_run();
  end
endmodule